// File: doc/BRIEF.md
# Eight-Entry Label Match Filter

This block sits beside a serial-word receiver and decides, word by word, whether the receiver may announce what it has received. It keeps a table of eight 8-bit labels. When the receiver finishes the first byte of a word, that byte (the label) is compared against all eight entries at once. On a hit, the receiver's ready and first-character strobes pass through to the host. On a miss, both strobes are suppressed for the rest of that word. A miss is not an error, and no error is signalled for it.

The host fills and inspects the table through the shared byte-wide data port, not through addressed registers. A control write that takes the label-enable bit from 0 to 1 opens a load window, and the next eight data writes fill entries 1 to 8 in order. A control write that takes the readback bit from 0 to 1 opens a readback window, and the next eight data reads return entries 1 to 8 in order. Each 0-to-1 transition opens the window once. Control writes and status reads that land inside a window do not advance it.

Filtering applies only while the hardware feature-select input is high and the label-enable bit is set. Every rising edge of feature-select marks the table stale, and the table must then be reloaded in full.

Top module: `label_match_filter`

## Requirements
- R1: After reset, lbl_rd_valid, rb_window, rx_rdy_o and rx_first_o are all 0, and both windows are closed.
- R2: The load window opens on a control write (bus_ctl=1) with bus_wdata bit 7 (label-enable) at 1 while the stored enable bit is 0 and feat_sel is 1. The next eight data writes (bus_ctl=0) store entries 1 to 8 in order. Any further data write changes no entry.
- R3: The readback window opens on a control write with bus_wdata bit 1 at 1 while the stored readback bit is 0. On each of the next eight data reads, lbl_rd_valid pulses for one cycle, starting the cycle after the read, and lbl_rd_data carries entries 1 to 8 in order. A ninth read produces no pulse. A control write that leaves the bit at 1 does not reopen the window. rb_window is high while the window is open.
- R4: Control writes and status reads (bus_ctl=1) made inside an open window do not advance it.
- R5: While filtering is active and the table is complete, a captured label equal to any entry lets rx_rdy_i and rx_first_i through to rx_rdy_o and rx_first_o, one cycle later.
- R6: While filtering is active, a captured label that matches no entry holds rx_rdy_o and rx_first_o at 0, and the block raises no other indication.
- R7: When feat_sel is 0 or the stored label-enable bit is 0, every ready and first-character strobe passes through one cycle later, whatever the label.
- R8: A rising edge of feat_sel, or the opening of a load window, marks the table stale. While the table is stale and filtering is active, every word is suppressed. The table becomes valid again only when the eighth entry of a load window is written.
- R9: The label is captured in the cycle in which rx_lbl_valid is high. That verdict governs every ready and first-character strobe until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| feat_sel | input | 1 | Hardware feature select; enables label filtering |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_ctl | input | 1 | 1 = control/status access, 0 = data access |
| bus_wdata | input | 8 | Host write data |
| lbl_rd_valid | output | 1 | Readback byte valid |
| lbl_rd_data | output | 8 | Readback label byte |
| rb_window | output | 1 | Readback window open; data reads route to the table |
| rx_lbl_valid | input | 1 | First received byte complete |
| rx_lbl | input | 8 | First received byte (label) |
| rx_rdy_i | input | 1 | Receiver ready strobe before filtering |
| rx_first_i | input | 1 | Receiver first-character strobe before filtering |
| rx_rdy_o | output | 1 | Filtered ready strobe |
| rx_first_o | output | 1 | Filtered first-character strobe |

## Verification
A table write takes effect at the clock edge that samples the data write. A readback byte appears with lbl_rd_valid one cycle after the edge that samples the data read. The filtered strobes follow their inputs one cycle later, and they use the verdict registered at the most recent rx_lbl_valid edge. The driver changes inputs just after a rising edge and records the expected byte or strobe pair when it issues the access. The monitor samples on the falling edge that follows the sampling edge, so each comparison falls in the cycle where the result is due. Queues that end the run non-empty expose results that never arrived, and valid pulses with nothing queued expose spurious readback.

// File: rtl/lblf_pkg.sv
`timescale 1ns/1ps
package lblf_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic ctl;
  } host_acc_t;

  function automatic logic is_data(host_acc_t a);
    return !a.ctl;
  endfunction
endpackage

// File: rtl/lblf_window.sv
`timescale 1ns/1ps
module lblf_window #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 open_i,
  input  logic                 step_i,
  output logic                 act_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o <= 1'b0;
      idx_o <= '0;
    end else if (open_i) begin
      act_o <= 1'b1;
      idx_o <= '0;
    end else if (step_i && act_o) begin
      if (idx_o == LAST) begin
        act_o <= 1'b0;
        idx_o <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end

  assert_open_needs_ctl_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act_o) |-> $past(open_i));

  assert_hold_without_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !open_i) |=> $stable(idx_o) && $stable(act_o));
endmodule

// File: rtl/lblf_table.sv
`timescale 1ns/1ps
module lblf_table #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic                 rd_en,
  input  logic [$clog2(N)-1:0] rd_idx,
  input  logic [W-1:0]         cmp_lbl,
  output logic                 rd_valid_o,
  output logic [W-1:0]         rd_data_o,
  output logic                 hit_o
);
  localparam int IW = $clog2(N);

  logic [W-1:0] mem [N];
  logic [N-1:0] hits;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data_o <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= rd_en;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = (mem[g] == cmp_lbl);

    assert_entry_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !($past(wr_en) && ($past(wr_idx) == IW'(g))) |-> $stable(mem[g]));
  end

  assign hit_o = |hits;

  assert_rd_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_en));
endmodule

// File: rtl/lblf_gate.sv
`timescale 1ns/1ps
module lblf_gate (
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  logic pass_i,
  input  logic filt_en_i,
  input  logic rdy_i,
  input  logic first_i,
  output logic rdy_o,
  output logic first_o
);
  logic pass_q;
  logic allow;

  always_ff @(posedge clk) begin
    if (rst)        pass_q <= 1'b0;
    else if (cap_i) pass_q <= pass_i;
  end

  assign allow = !filt_en_i || pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_o   <= 1'b0;
      first_o <= 1'b0;
    end else begin
      rdy_o   <= rdy_i && allow;
      first_o <= first_i && allow;
    end
  end

  assert_no_spurious_ready_R5: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> $past(rdy_i));

  assert_no_spurious_first_R6: assert property (@(posedge clk) disable iff (rst)
    first_o |-> $past(first_i));
endmodule

// File: rtl/label_match_filter.sv
`timescale 1ns/1ps
module label_match_filter #(
  parameter int N_LBL  = 8,
  parameter int LBL_W  = 8,
  parameter int BUS_W  = 8,
  parameter int EN_BIT = 7,
  parameter int RB_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feat_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_ctl,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic             lbl_rd_valid,
  output logic [LBL_W-1:0] lbl_rd_data,
  output logic             rb_window,
  input  logic             rx_lbl_valid,
  input  logic [LBL_W-1:0] rx_lbl,
  input  logic             rx_rdy_i,
  input  logic             rx_first_i,
  output logic             rx_rdy_o,
  output logic             rx_first_o
);
  import lblf_pkg::*;

  localparam int IW = $clog2(N_LBL);
  localparam logic [IW-1:0] LAST = IW'(N_LBL - 1);

  host_acc_t acc;
  logic en_q, rb_q, feat_q, tbl_ok;
  logic ctl_wr, open_ld, open_rb, ld_step, rb_step;
  logic ld_act, rb_act, wr_en, rd_en, hit, filt_en;
  logic [IW-1:0] ld_idx, rb_idx;

  assign acc     = '{wr: bus_wr, rd: bus_rd, ctl: bus_ctl};
  assign ctl_wr  = acc.wr && !is_data(acc);
  assign open_ld = ctl_wr && bus_wdata[EN_BIT] && !en_q && feat_sel;
  assign open_rb = ctl_wr && bus_wdata[RB_BIT] && !rb_q;
  assign ld_step = acc.wr && is_data(acc);
  assign rb_step = acc.rd && is_data(acc);
  assign wr_en   = ld_step && ld_act;
  assign rd_en   = rb_step && rb_act;
  assign filt_en = feat_sel && en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      rb_q   <= 1'b0;
      feat_q <= 1'b0;
    end else begin
      feat_q <= feat_sel;
      if (ctl_wr) begin
        en_q <= bus_wdata[EN_BIT];
        rb_q <= bus_wdata[RB_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               tbl_ok <= 1'b0;
    else if ((feat_sel && !feat_q) || open_ld) tbl_ok <= 1'b0;
    else if (wr_en && ld_idx == LAST)      tbl_ok <= 1'b1;
  end

  lblf_window #(.N(N_LBL)) u_ld_win (
    .clk(clk), .rst(rst), .open_i(open_ld), .step_i(ld_step),
    .act_o(ld_act), .idx_o(ld_idx)
  );

  lblf_window #(.N(N_LBL)) u_rb_win (
    .clk(clk), .rst(rst), .open_i(open_rb), .step_i(rb_step),
    .act_o(rb_act), .idx_o(rb_idx)
  );

  lblf_table #(.N(N_LBL), .W(LBL_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(ld_idx), .wr_data(bus_wdata[LBL_W-1:0]),
    .rd_en(rd_en), .rd_idx(rb_idx), .cmp_lbl(rx_lbl),
    .rd_valid_o(lbl_rd_valid), .rd_data_o(lbl_rd_data), .hit_o(hit)
  );

  lblf_gate u_gate (
    .clk(clk), .rst(rst), .cap_i(rx_lbl_valid), .pass_i(hit && tbl_ok),
    .filt_en_i(filt_en), .rdy_i(rx_rdy_i), .first_i(rx_first_i),
    .rdy_o(rx_rdy_o), .first_o(rx_first_o)
  );

  assign rb_window = rb_act;

  assert_stale_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (feat_sel && !feat_q) |=> !tbl_ok);

  assert_rb_opens_on_ctl_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_window) |-> $past(ctl_wr));
endmodule

// File: tb/label_match_filter_bench.sv
`timescale 1ns/1ps
module label_match_filter_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, feat_sel, bus_wr, bus_rd, bus_ctl;
  logic [7:0] bus_wdata, lbl_rd_data, rx_lbl;
  logic lbl_rd_valid, rb_window, rx_lbl_valid, rx_rdy_i, rx_first_i;
  logic rx_rdy_o, rx_first_o;

  label_match_filter u_label_match_filter (
    .clk(clk), .rst(rst), .feat_sel(feat_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctl(bus_ctl), .bus_wdata(bus_wdata),
    .lbl_rd_valid(lbl_rd_valid), .lbl_rd_data(lbl_rd_data), .rb_window(rb_window),
    .rx_lbl_valid(rx_lbl_valid), .rx_lbl(rx_lbl),
    .rx_rdy_i(rx_rdy_i), .rx_first_i(rx_first_i),
    .rx_rdy_o(rx_rdy_o), .rx_first_o(rx_first_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rx_chk = 0;
  logic [7:0] exp_rd[$];
  string      exp_rd_tag[$];
  logic [1:0] exp_rx[$];
  string      exp_rx_tag[$];

  function automatic logic [7:0] lab(int i);
    return 8'(8'h15 + i * 8'h21);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected results in the cycle they are due
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rx_chk) begin
        if (exp_rx.size() == 0) check(0, "R5", "strobe without expectation", 0, 0);
        else begin
          logic [1:0] e;
          string t;
          e = exp_rx.pop_front();
          t = exp_rx_tag.pop_front();
          check({rx_rdy_o, rx_first_o} == e, t, "filtered rdy/first", {rx_rdy_o, rx_first_o}, e);
        end
      end
      rx_chk = rx_rdy_i;
      if (lbl_rd_valid) begin
        if (exp_rd.size() == 0) check(0, "R3", "unexpected readback", lbl_rd_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_rd.pop_front();
          t = exp_rd_tag.pop_front();
          check(lbl_rd_data == e, t, "readback label", lbl_rd_data, e);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ctl_write(logic [7:0] d);
    bus_wr = 1; bus_ctl = 1; bus_wdata = d; cyc(); bus_wr = 0; bus_ctl = 0;
  endtask

  task automatic stat_read();
    bus_rd = 1; bus_ctl = 1; cyc(); bus_rd = 0; bus_ctl = 0;
  endtask

  task automatic dat_write(logic [7:0] d);
    bus_wr = 1; bus_ctl = 0; bus_wdata = d; cyc(); bus_wr = 0;
  endtask

  task automatic dat_read(bit expect_v, logic [7:0] e, string tag);
    if (expect_v) begin exp_rd.push_back(e); exp_rd_tag.push_back(tag); end
    bus_rd = 1; bus_ctl = 0; cyc(); bus_rd = 0;
  endtask

  task automatic rx_word(logic [7:0] l, bit pass, string tag, int npulse);
    rx_lbl_valid = 1; rx_lbl = l; cyc(); rx_lbl_valid = 0;
    for (int p = 0; p < npulse; p++) begin
      exp_rx.push_back({pass, pass}); exp_rx_tag.push_back(tag);
      rx_rdy_i = 1; rx_first_i = 1; cyc(); rx_rdy_i = 0; rx_first_i = 0; cyc();
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < 8; i++) dat_write(lab(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "R1", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; feat_sel = 0; bus_wr = 0; bus_rd = 0; bus_ctl = 0; bus_wdata = 0;
    rx_lbl_valid = 0; rx_lbl = 0; rx_rdy_i = 0; rx_first_i = 0;
    repeat (5) cyc();
    rst = 0;
    cyc();
    @(negedge clk);
    check(lbl_rd_valid == 0, "R1", "rd_valid after reset", lbl_rd_valid, 0);
    check(rb_window == 0, "R1", "rb_window after reset", rb_window, 0);
    check(rx_rdy_o == 0 && rx_first_o == 0, "R1", "strobes after reset", {rx_rdy_o, rx_first_o}, 0);
    cyc();

    // R7: filter off with feature select low
    rx_word(8'hEE, 1, "R7", 1);

    // R2/R4/R8: load window with interleaved control accesses
    feat_sel = 1; cyc();
    ctl_write(8'h00);
    ctl_write(8'h80);
    for (int i = 0; i < 4; i++) dat_write(lab(i));
    stat_read();
    ctl_write(8'h80);
    rx_word(lab(0), 0, "R8", 1);
    for (int i = 4; i < 8; i++) dat_write(lab(i));
    dat_write(8'hEE);

    rx_word(lab(3), 1, "R5", 1);
    rx_word(lab(7), 1, "R5", 1);
    rx_word(8'hEE, 0, "R2", 1);
    rx_word(8'h00, 0, "R6", 1);

    // R3/R4: readback window
    ctl_write(8'h82);
    @(negedge clk);
    check(rb_window == 1, "R3", "rb_window open", rb_window, 1);
    cyc();
    for (int i = 0; i < 4; i++) dat_read(1, lab(i), "R3");
    stat_read();
    ctl_write(8'h82);
    for (int i = 4; i < 8; i++) dat_read(1, lab(i), "R4");
    dat_read(0, 8'h00, "R3");
    @(negedge clk);
    check(rb_window == 0, "R3", "rb_window closed after eight", rb_window, 0);
    cyc();
    ctl_write(8'h82);
    dat_read(0, 8'h00, "R3");
    ctl_write(8'h80);
    ctl_write(8'h82);
    dat_read(1, lab(0), "R3");

    // R9: verdict holds across repeated strobes
    rx_word(8'h00, 0, "R9", 2);
    rx_word(lab(5), 1, "R9", 2);

    // R7: enable bit cleared
    ctl_write(8'h02);
    rx_word(8'h00, 1, "R7", 1);

    // R8: feature-select rising edge makes the table stale
    feat_sel = 0; cyc();
    ctl_write(8'h80);
    rx_word(8'h00, 1, "R7", 1);
    feat_sel = 1; cyc();
    rx_word(lab(3), 0, "R8", 1);
    ctl_write(8'h00);
    ctl_write(8'h80);
    load_all();
    rx_word(lab(3), 1, "R8", 1);
    rx_word(8'hEE, 0, "R6", 1);

    repeat (3) cyc();
    check(exp_rd.size() == 0, "R3", "readbacks outstanding", exp_rd.size(), 0);
    check(exp_rx.size() == 0, "R5", "strobes outstanding", exp_rx.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule